// File: doc/BRIEF.md
# Paired-Page Translation Lookup Unit

This block is a fully associative address translation buffer in which every entry describes two neighbouring virtual pages, an even one and an odd one. The pair shares one virtual tag, one page-size mask and one address-space tag. Each half has its own physical frame base, its own valid bit and its own dirty (write-enable) bit. A lookup takes a virtual address, the current 8-bit address-space identifier and a load/store flag. One cycle later it returns a result code, a physical address and a writable flag.

Entries are loaded through a write port that names an index and supplies all fields of that entry. The page-size mask widens both halves together. A mask of zero gives 4 KiB pages, which is an 8 KiB pair. Smaller pages are not supported. When several entries match the same address, the entry with the lowest index decides the result. The result code tells a plain miss apart from a matched-but-invalid half and from a store to a clean half.

Top module: `tlb_pair_lookup`

## Requirements
- R1: Reset clears every entry to all-zero fields and drives `rsp_valid` low. After reset, a load of an address below 0x2000 with identifier 0x00 returns INVALID, and any lookup with a non-zero identifier returns NOMATCH.
- R2: `rsp_valid` is high in exactly the cycle after a cycle with `req` high. The result fields are captured from the request cycle. Consecutive requests give consecutive responses. The code encoding is 00 MATCH, 01 INVALID, 10 DIRTY, 11 NOMATCH.
- R3: An entry takes part only when its global bit is set or its identifier equals `cur_asid`.
- R4: The effective mask of an entry is its page-mask field placed at address bit 13 and up, ORed with ones in bits 12..0. The entry matches when the address and the entry tag agree on every bit outside the effective mask.
- R5: The half is selected by the highest set bit of the effective mask (bit 12 for a zero mask, bit 14 for mask 0x0003). That address bit set selects the odd half.
- R6: On MATCH, `rsp_pa` is the selected half's frame base ORed with the address bits under the effective mask shifted right by one, and `rsp_wr` equals that half's dirty bit.
- R7: When the selected half's valid bit is clear, the result is INVALID for loads and stores alike.
- R8: A store to a valid half whose dirty bit is clear returns DIRTY. A load to a valid half is always MATCH.
- R9: When no entry matches, the result is NOMATCH. For every code other than MATCH, `rsp_pa` is zero and `rsp_wr` is low.
- R10: Among several matching entries, the lowest index alone decides the result, even when that entry gives a fault.
- R11: A write lands on the clock edge that ends its cycle. A lookup in the same cycle sees the entry's earlier contents, and the next lookup sees the new contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Load the entry at `wr_idx` |
| wr_idx | input | 4 | Entry index to load |
| wr_vpn2 | input | 32 | Virtual tag of the page pair |
| wr_mask | input | 16 | Page-mask field (address bits 13 up) |
| wr_asid | input | 8 | Address-space tag of the entry |
| wr_global | input | 1 | Entry matches any identifier |
| wr_pfn0 | input | 32 | Physical base of the even half |
| wr_pfn1 | input | 32 | Physical base of the odd half |
| wr_v0 | input | 1 | Even half valid |
| wr_v1 | input | 1 | Odd half valid |
| wr_d0 | input | 1 | Even half writable |
| wr_d1 | input | 1 | Odd half writable |
| req | input | 1 | Lookup strobe |
| va | input | 32 | Virtual address to translate |
| cur_asid | input | 8 | Current address-space identifier |
| is_store | input | 1 | Access is a store |
| rsp_valid | output | 1 | Result valid, one cycle after `req` |
| rsp_code | output | 2 | Result class |
| rsp_pa | output | 32 | Physical address on MATCH, else zero |
| rsp_wr | output | 1 | Page writable on MATCH |

## Verification
A lookup and an entry write can fall in the same cycle and can address the same entry. The bench provokes this by raising `wr_en` and `req` together on the entry that currently wins a lookup. It first turns that entry's valid bit off and later moves its tag away. The response to the coinciding lookup must still reflect the old contents. The lookup after it must show INVALID and then the result of the next-lowest matching entry.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  typedef enum logic [1:0] {
    RES_MATCH   = 2'b00,
    RES_INVALID = 2'b01,
    RES_DIRTY   = 2'b10,
    RES_NOMATCH = 2'b11
  } tlb_res_e;
endpackage

// File: rtl/tlbp_match_cell.sv
// Compare of one paired-page entry against the lookup address.
module tlbp_match_cell #(
  parameter int VA_W       = 32,
  parameter int MASK_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8
) (
  input  logic [VA_W-1:0]   ent_vpn2,
  input  logic [MASK_W-1:0] ent_mask,
  input  logic [ASID_W-1:0] ent_asid,
  input  logic              ent_global,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  output logic              hit,
  output logic              odd,
  output logic [VA_W-1:0]   half_mask
);
  localparam int LOW_W = PAGE_SHIFT + 1;
  localparam int TOP_W = VA_W - MASK_W - LOW_W;

  logic [VA_W-1:0] pair_mask;
  logic            owner_ok;
  logic            tag_ok;

  always_comb begin
    pair_mask = {{TOP_W{1'b0}}, ent_mask, {LOW_W{1'b1}}};
    half_mask = pair_mask >> 1;
    owner_ok  = ent_global || (ent_asid == cur_asid);
    tag_ok    = ((ent_vpn2 & ~pair_mask) == (va & ~pair_mask));
    hit       = owner_ok && tag_ok;
    odd       = |(va & pair_mask & ~half_mask);
  end
endmodule

// File: rtl/tlbp_first_hit.sv
// Lowest-index-wins priority pick over the hit vector.
module tlbp_first_hit #(
  parameter int N     = 16,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     hits,
  output logic             any,
  output logic [IDX_W-1:0] idx
);
  always_comb begin
    any = |hits;
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (hits[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/tlb_pair_lookup.sv
module tlb_pair_lookup #(
  parameter int ENTRIES    = 16,
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int MASK_W     = 16,
  parameter int PAGE_SHIFT = 12,
  parameter int ASID_W     = 8,
  localparam int IDX_W     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [VA_W-1:0]   wr_vpn2,
  input  logic [MASK_W-1:0] wr_mask,
  input  logic [ASID_W-1:0] wr_asid,
  input  logic              wr_global,
  input  logic [PA_W-1:0]   wr_pfn0,
  input  logic [PA_W-1:0]   wr_pfn1,
  input  logic              wr_v0,
  input  logic              wr_v1,
  input  logic              wr_d0,
  input  logic              wr_d1,
  input  logic              req,
  input  logic [VA_W-1:0]   va,
  input  logic [ASID_W-1:0] cur_asid,
  input  logic              is_store,
  output logic              rsp_valid,
  output logic [1:0]        rsp_code,
  output logic [PA_W-1:0]   rsp_pa,
  output logic              rsp_wr
);
  import tlbp_pkg::*;

  // entry storage
  logic [VA_W-1:0]   e_vpn2 [ENTRIES];
  logic [MASK_W-1:0] e_mask [ENTRIES];
  logic [ASID_W-1:0] e_asid [ENTRIES];
  logic              e_glob [ENTRIES];
  logic [PA_W-1:0]   e_pfn0 [ENTRIES];
  logic [PA_W-1:0]   e_pfn1 [ENTRIES];
  logic [1:0]        e_vld  [ENTRIES];
  logic [1:0]        e_dty  [ENTRIES];

  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] odd_vec;
  logic [VA_W-1:0]    hmask  [ENTRIES];

  genvar g;
  generate
    for (g = 0; g < ENTRIES; g++) begin : gen_ent
      logic ld;
      always_comb ld = wr_en && (wr_idx == IDX_W'(g));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          e_vpn2[g] <= '0;
          e_mask[g] <= '0;
          e_asid[g] <= '0;
          e_glob[g] <= 1'b0;
          e_pfn0[g] <= '0;
          e_pfn1[g] <= '0;
          e_vld[g]  <= '0;
          e_dty[g]  <= '0;
        end else if (ld) begin
          e_vpn2[g] <= wr_vpn2;
          e_mask[g] <= wr_mask;
          e_asid[g] <= wr_asid;
          e_glob[g] <= wr_global;
          e_pfn0[g] <= wr_pfn0;
          e_pfn1[g] <= wr_pfn1;
          e_vld[g]  <= {wr_v1, wr_v0};
          e_dty[g]  <= {wr_d1, wr_d0};
        end
      end

      tlbp_match_cell #(
        .VA_W(VA_W), .MASK_W(MASK_W), .PAGE_SHIFT(PAGE_SHIFT), .ASID_W(ASID_W)
      ) u_cell (
        .ent_vpn2  (e_vpn2[g]),
        .ent_mask  (e_mask[g]),
        .ent_asid  (e_asid[g]),
        .ent_global(e_glob[g]),
        .va        (va),
        .cur_asid  (cur_asid),
        .hit       (hit_vec[g]),
        .odd       (odd_vec[g]),
        .half_mask (hmask[g])
      );
    end
  endgenerate

  logic             any_hit;
  logic [IDX_W-1:0] win;

  tlbp_first_hit #(.N(ENTRIES)) u_pick (
    .hits(hit_vec),
    .any (any_hit),
    .idx (win)
  );

  // classification of the winning entry
  logic            sel_odd;
  logic            sel_v;
  logic            sel_d;
  logic [PA_W-1:0] sel_pfn;
  tlb_res_e        code_nxt;
  logic [PA_W-1:0] pa_nxt;
  logic            wr_nxt;

  always_comb begin
    sel_odd = odd_vec[win];
    sel_v   = e_vld[win][sel_odd];
    sel_d   = e_dty[win][sel_odd];
    sel_pfn = sel_odd ? e_pfn1[win] : e_pfn0[win];
    if (!any_hit)               code_nxt = RES_NOMATCH;
    else if (!sel_v)            code_nxt = RES_INVALID;
    else if (is_store && !sel_d) code_nxt = RES_DIRTY;
    else                        code_nxt = RES_MATCH;
    pa_nxt = '0;
    wr_nxt = 1'b0;
    if (code_nxt == RES_MATCH) begin
      pa_nxt = sel_pfn | PA_W'(va & hmask[win]);
      wr_nxt = sel_d;
    end
  end

  // response registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
    end else begin
      rsp_valid <= req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_code <= RES_NOMATCH;
      rsp_pa   <= '0;
      rsp_wr   <= 1'b0;
    end else if (req) begin
      rsp_code <= code_nxt;
      rsp_pa   <= pa_nxt;
      rsp_wr   <= wr_nxt;
    end
  end
endmodule

// File: rtl/tlb_pair_lookup_chk.sv
module tlb_pair_lookup_chk #(
  parameter int VA_W       = 32,
  parameter int PA_W       = 32,
  parameter int PAGE_SHIFT = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [VA_W-1:0] va,
  input logic            is_store,
  input logic            rsp_valid,
  input logic [1:0]      rsp_code,
  input logic [PA_W-1:0] rsp_pa,
  input logic            rsp_wr
);
  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rsp_valid); // R2
  AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    !req |=> !rsp_valid); // R2
  AST_FAULT_ZERO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code != 2'b00) |-> (rsp_pa == '0 && !rsp_wr)); // R9
  AST_STORE_HIT_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b00 && $past(is_store)) |-> rsp_wr); // R8
  AST_DIRTY_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b10) |-> $past(is_store)); // R8
  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_code == 2'b00) |->
      (rsp_pa[PAGE_SHIFT-1:0] == $past(va[PAGE_SHIFT-1:0]))); // R6
endmodule

bind tlb_pair_lookup tlb_pair_lookup_chk #(
  .VA_W(VA_W), .PA_W(PA_W), .PAGE_SHIFT(PAGE_SHIFT)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req      (req),
  .va       (va),
  .is_store (is_store),
  .rsp_valid(rsp_valid),
  .rsp_code (rsp_code),
  .rsp_pa   (rsp_pa),
  .rsp_wr   (rsp_wr)
);

// File: tb/tlb_pair_lookup_test.sv
module tlb_pair_lookup_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_idx;
  logic [31:0] wr_vpn2;
  logic [15:0] wr_mask;
  logic [7:0]  wr_asid;
  logic        wr_global;
  logic [31:0] wr_pfn0, wr_pfn1;
  logic        wr_v0, wr_v1, wr_d0, wr_d1;
  logic        req;
  logic [31:0] va;
  logic [7:0]  cur_asid;
  logic        is_store;
  logic        rsp_valid;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_pa;
  logic        rsp_wr;

  int tests = 0;
  int fails = 0;

  logic [34:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  tlb_pair_lookup uut (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_vpn2(wr_vpn2), .wr_mask(wr_mask),
    .wr_asid(wr_asid), .wr_global(wr_global), .wr_pfn0(wr_pfn0), .wr_pfn1(wr_pfn1),
    .wr_v0(wr_v0), .wr_v1(wr_v1), .wr_d0(wr_d0), .wr_d1(wr_d1),
    .req(req), .va(va), .cur_asid(cur_asid), .is_store(is_store),
    .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_pa(rsp_pa), .rsp_wr(rsp_wr)
  );

  // monitor: pops expectations as responses appear
  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      tests++;
      if (exp_q.size() == 0) begin
        fails++;
        $display("FAIL R2: response with no request, got code=%b pa=%h wr=%b, expected none",
                 rsp_code, rsp_pa, rsp_wr);
      end else begin
        logic [34:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if ({rsp_code, rsp_pa, rsp_wr} !== e) begin
          fails++;
          $display("FAIL %s: got code=%b pa=%h wr=%b, expected code=%b pa=%h wr=%b",
                   t, rsp_code, rsp_pa, rsp_wr, e[34:33], e[32:1], e[0]);
        end
      end
    end
  end

  task automatic set_entry(input logic [3:0] idx, input logic [31:0] vpn2,
                           input logic [15:0] msk, input logic [7:0] asid, input logic glob,
                           input logic [31:0] p0, input logic [31:0] p1,
                           input logic v0, input logic v1, input logic d0, input logic d1);
    wr_en = 1'b1; wr_idx = idx; wr_vpn2 = vpn2; wr_mask = msk; wr_asid = asid;
    wr_global = glob; wr_pfn0 = p0; wr_pfn1 = p1;
    wr_v0 = v0; wr_v1 = v1; wr_d0 = d0; wr_d1 = d1;
  endtask

  task automatic set_lookup(input logic [31:0] a, input logic [7:0] asid, input logic st,
                            input logic [1:0] code, input logic [31:0] pa, input logic wr,
                            input string t);
    req = 1'b1; va = a; cur_asid = asid; is_store = st;
    exp_q.push_back({code, pa, wr});
    tag_q.push_back(t);
  endtask

  task automatic step();
    @(negedge clk);
    req = 1'b0;
    wr_en = 1'b0;
  endtask

  task automatic lookup(input logic [31:0] a, input logic [7:0] asid, input logic st,
                        input logic [1:0] code, input logic [31:0] pa, input logic wr,
                        input string t);
    set_lookup(a, asid, st, code, pa, wr, t);
    step();
  endtask

  task automatic check_bit(input logic act, input logic exp_v, input string t);
    tests++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s: got %b, expected %b", t, act, exp_v);
    end
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_vpn2 = '0; wr_mask = '0; wr_asid = '0;
    wr_global = 1'b0; wr_pfn0 = '0; wr_pfn1 = '0; wr_v0 = 1'b0; wr_v1 = 1'b0;
    wr_d0 = 1'b0; wr_d1 = 1'b0; req = 1'b0; va = '0; cur_asid = '0; is_store = 1'b0;
    repeat (3) @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R1 rsp_valid in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R1 rsp_valid after reset");

    // R1: zeroed entries
    lookup(32'h0000_0000, 8'h00, 1'b0, 2'b01, 32'h0, 1'b0, "R1 zero entry invalid");
    lookup(32'h0000_1000, 8'h33, 1'b0, 2'b11, 32'h0, 1'b0, "R1 other asid nomatch");

    // 4 KiB pair at idx 2, even writable, odd clean
    set_entry(4'd2, 32'h0040_0000, 16'h0000, 8'h11, 1'b0,
              32'h1000_0000, 32'h2000_0000, 1'b1, 1'b1, 1'b1, 1'b0);
    step();
    lookup(32'h0040_0123, 8'h11, 1'b0, 2'b00, 32'h1000_0123, 1'b1, "R6 even half merge");
    lookup(32'h0040_1ABC, 8'h11, 1'b0, 2'b00, 32'h2000_0ABC, 1'b0, "R5 odd half by bit12");
    lookup(32'h0040_1ABC, 8'h11, 1'b1, 2'b10, 32'h0, 1'b0, "R8 store to clean half");
    lookup(32'h0040_0004, 8'h11, 1'b1, 2'b00, 32'h1000_0004, 1'b1, "R8 store to dirty half");
    lookup(32'h0040_0123, 8'h12, 1'b0, 2'b11, 32'h0, 1'b0, "R3 asid mismatch");
    lookup(32'h0040_2000, 8'h11, 1'b0, 2'b11, 32'h0, 1'b0, "R4 tag bit13 differs");
    lookup(32'h0123_4000, 8'h11, 1'b1, 2'b11, 32'h0, 1'b0, "R9 unmapped store");

    // 16 KiB pages, global, even half invalid
    set_entry(4'd5, 32'h0080_0000, 16'h0003, 8'h99, 1'b1,
              32'h3000_0000, 32'h3100_0000, 1'b0, 1'b1, 1'b0, 1'b1);
    step();
    lookup(32'h0080_5678, 8'h42, 1'b0, 2'b00, 32'h3100_1678, 1'b1, "R4 wide mask global hit");
    lookup(32'h0080_2000, 8'h07, 1'b0, 2'b01, 32'h0, 1'b0, "R5 bit13 inside even page");
    lookup(32'h0080_3FFC, 8'h07, 1'b1, 2'b01, 32'h0, 1'b0, "R7 store to invalid half");
    lookup(32'h0080_8000, 8'h07, 1'b0, 2'b11, 32'h0, 1'b0, "R4 beyond 32 KiB pair");

    // overlapping entries 7 and 9
    set_entry(4'd7, 32'h00C0_0000, 16'h0000, 8'h00, 1'b1,
              32'h4000_0000, 32'h0, 1'b1, 1'b0, 1'b0, 1'b0);
    step();
    set_entry(4'd9, 32'h00C0_0000, 16'h0000, 8'h00, 1'b1,
              32'h5000_0000, 32'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    lookup(32'h00C0_0010, 8'h01, 1'b0, 2'b00, 32'h4000_0010, 1'b0, "R10 lower index wins");
    lookup(32'h00C0_0010, 8'h01, 1'b1, 2'b10, 32'h0, 1'b0, "R10 lower index fault wins");

    // write and lookup in the same cycle on the winning entry
    set_entry(4'd7, 32'h00C0_0000, 16'h0000, 8'h00, 1'b1,
              32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    set_lookup(32'h00C0_0010, 8'h01, 1'b0, 2'b00, 32'h4000_0010, 1'b0, "R11 same cycle sees old");
    step();
    lookup(32'h00C0_0010, 8'h01, 1'b0, 2'b01, 32'h0, 1'b0, "R11 next sees new invalid");
    set_entry(4'd7, 32'h0F00_0000, 16'h0000, 8'h00, 1'b1,
              32'h4000_0000, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    set_lookup(32'h00C0_0010, 8'h01, 1'b1, 2'b01, 32'h0, 1'b0, "R11 same cycle old tag");
    step();
    lookup(32'h00C0_0010, 8'h01, 1'b1, 2'b00, 32'h5000_0010, 1'b1, "R10 falls to idx9");

    // idle: no response without a request
    repeat (2) @(negedge clk);
    check_bit(rsp_valid, 1'b0, "R2 idle no response");
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R2: %0d responses missing, expected 0", exp_q.size());
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL R2: watchdog expired, got hang, expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule